// File: doc/BRIEF.md
# Tri-Level PWM Gate Drive Sequencer

This block sits between the PWM input decoder of a synchronous buck power stage and its two gate drivers. Each clock it takes a decoded three-level command (drive high, drive low or mid-level), an active-low brake input and a zero-current comparator bit. From these it produces one enable for the high-side switch and one for the low-side switch. A fixed dead-time keeps the two enables from ever being on together.

What the mid level means is fixed once per power cycle. During a short window after the supply-ok flag rises, the block watches the brake input. If brake is low in any cycle of that window, the block enters diode-emulation mode. Otherwise it stays in brake mode. Diode-emulation mode stays set until supply-ok drops again.

In brake mode a mid-level command turns both switches off. In diode-emulation mode a mid-level command keeps the low-side switch conducting until one of two things happens: the zero-current comparator trips after a blanking window that starts when the low-side gate turns on, or a timeout runs out. In either case the switch node is then left floating.

Top module: `tri_pwm_gate_seq`

## Requirements
- R1: While `supplyOk` is low, both gate enables and `modeDiode` are 0 one clock later, and they stay 0 until `supplyOk` returns.
- R2: Command `2'b01` (high) with brake released drives `hsGate` to 1 and `lsGate` to 0, after any dead-time.
- R3: Command `2'b00` (low) with brake released drives `lsGate` to 1 and `hsGate` to 0, after any dead-time.
- R4: `brakeN` low forces both gate enables to 0 on the next clock, whatever the command. Once `brakeN` is released, command control resumes.
- R5: If `brakeN` is low in any of the first `SEL_WINDOW` cycles after `supplyOk` rises, `modeDiode` becomes 1. Otherwise `modeDiode` stays 0 (brake mode).
- R6: Once `modeDiode` is 1, later activity on `brakeN` does not clear it. Only a low `supplyOk` clears it.
- R7: In brake mode, a mid-level command (`pwmCmd[1]` = 1) turns both gate enables off on the next clock.
- R8: In diode-emulation mode, a mid-level command turns `hsGate` off and holds `lsGate` on (turning it on after dead-time if needed) until the zero-current or timeout condition occurs. After that, both enables are 0 while the command stays mid-level.
- R9: `zeroCross` is ignored until `lsGate` has been 1 for `BLANK_CYCLES`+1 consecutive clocks.
- R10: If `zeroCross` is not accepted within `TIMEOUT_CYCLES`+1 clocks of mid-level in diode-emulation mode, `lsGate` turns off.
- R11: `hsGate` and `lsGate` are never 1 together. Between one switch turning off and the other turning on, both are 0 for `DEAD_CYCLES`+1 clocks.
- R12: When the command leaves mid-level for high or low, the matching gate turns on after the dead-time, and a later mid-level entry restarts the diode-emulation sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| supplyOk | input | 1 | Hysteretic supply-ok flag; low acts as synchronous reset |
| pwmCmd | input | 2 | Decoded command: 00 low, 01 high, 1x mid-level |
| brakeN | input | 1 | Active-low brake and mode-select input |
| zeroCross | input | 1 | Zero-current comparator output, 1 when current reached zero |
| hsGate | output | 1 | High-side gate enable |
| lsGate | output | 1 | Low-side gate enable |
| modeDiode | output | 1 | 1 when diode-emulation mode is latched |

## Verification
The assertions assume that all inputs are already synchronous to `clk` and change only between edges. They also assume that `supplyOk` is held low for at least one clock before any check is relevant, so that the brake and mid-level properties do not fire on pre-reset state. The stimulus drives every input on the falling edge. It starts each power cycle with `supplyOk` low for several clocks. It keeps the mode-select pulses and zero-current events inside the windows the requirements name, and it compares the outputs on every clock against a behavioural reference model.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

  // Diode-emulation sequence state while the command is mid-level.
  typedef enum logic [1:0] {
    DE_IDLE    = 2'd0,
    DE_CONDUCT = 2'd1,
    DE_DONE    = 2'd2
  } deState_t;

  // Strobes from control to the gate datapath.
  typedef struct packed {
    logic reqHs;
    logic reqLs;
  } gateReq_t;

  localparam logic [1:0] CMD_LOW  = 2'b00;
  localparam logic [1:0] CMD_HIGH = 2'b01;

endpackage

// File: rtl/tpg_control.sv
module tpg_control
  import tpg_pkg::*;
#(
  parameter int SEL_WINDOW     = 4,
  parameter int BLANK_CYCLES   = 8,
  parameter int TIMEOUT_CYCLES = 1400
) (
  input  logic       clk,
  input  logic       supplyOk,
  input  logic [1:0] pwmCmd,
  input  logic       brakeN,
  input  logic       zeroCross,
  input  logic       lsGateFb,
  output logic       modeDiode,
  output gateReq_t   gateReq
);

  localparam int SEL_W   = $clog2(SEL_WINDOW + 1);
  localparam int BLANK_W = $clog2(BLANK_CYCLES + 1);
  localparam int TO_W    = $clog2(TIMEOUT_CYCLES + 1);

  logic [SEL_W-1:0]   selCnt;
  logic [BLANK_W-1:0] blankCnt;
  logic [TO_W-1:0]    toCnt;
  deState_t           deState;
  logic               modeReg;
  logic               isMid;
  logic               selOpen;
  logic               blankDone;
  logic               toExpired;

  assign isMid     = pwmCmd[1];
  assign selOpen   = (selCnt != SEL_W'(SEL_WINDOW));
  assign blankDone = (blankCnt == BLANK_W'(BLANK_CYCLES));
  assign toExpired = (toCnt == TO_W'(TIMEOUT_CYCLES));
  assign modeDiode = modeReg;

  // Power-up mode selection: sticky until supply-ok drops.
  always_ff @(posedge clk) begin
    if (!supplyOk) begin
      selCnt  <= '0;
      modeReg <= 1'b0;
    end else begin
      if (selOpen) begin
        selCnt <= selCnt + 1'b1;
        if (!brakeN) modeReg <= 1'b1;
      end
    end
  end

  // Blanking counter: cycles since the low-side gate turned on.
  always_ff @(posedge clk) begin
    if (!supplyOk || !lsGateFb) begin
      blankCnt <= '0;
    end else if (!blankDone) begin
      blankCnt <= blankCnt + 1'b1;
    end
  end

  // Diode-emulation sequencer.
  always_ff @(posedge clk) begin
    if (!supplyOk || !isMid || !modeReg) begin
      deState <= DE_IDLE;
      toCnt   <= '0;
    end else begin
      unique case (deState)
        DE_IDLE: begin
          deState <= DE_CONDUCT;
          toCnt   <= '0;
        end
        DE_CONDUCT: begin
          if ((zeroCross && blankDone) || toExpired) begin
            deState <= DE_DONE;
          end else begin
            toCnt <= toCnt + 1'b1;
          end
        end
        default: deState <= DE_DONE;
      endcase
    end
  end

  // Request decode.
  always_comb begin
    gateReq = '0;
    if (brakeN) begin
      if (pwmCmd == CMD_HIGH) begin
        gateReq.reqHs = 1'b1;
      end else if (pwmCmd == CMD_LOW) begin
        gateReq.reqLs = 1'b1;
      end else if (modeReg && (deState != DE_DONE)) begin
        gateReq.reqLs = 1'b1;
      end
    end
  end

  // R6
  mode_sticky_chk: assert property (@(posedge clk) disable iff (!supplyOk)
    ($past(modeReg) && $past(supplyOk)) |-> modeReg);

  // R10
  timeout_bound_chk: assert property (@(posedge clk) disable iff (!supplyOk)
    (deState == DE_CONDUCT && toExpired && isMid && modeReg) |=> (deState == DE_DONE));

  // R9
  blank_respect_chk: assert property (@(posedge clk) disable iff (!supplyOk)
    (deState == DE_CONDUCT && isMid && modeReg && !lsGateFb) |=> (deState != DE_DONE) || !isMid || toExpired || $past(toExpired));

endmodule

// File: rtl/tpg_datapath.sv
module tpg_datapath
  import tpg_pkg::*;
#(
  parameter int DEAD_CYCLES = 3
) (
  input  logic     clk,
  input  logic     supplyOk,
  input  gateReq_t gateReq,
  output logic     hsGate,
  output logic     lsGate
);

  localparam int DEAD_W = $clog2(DEAD_CYCLES + 1);

  logic [DEAD_W-1:0] deadCnt;
  logic              bothOff;
  logic              deadDone;

  assign bothOff  = !hsGate && !lsGate;
  assign deadDone = (deadCnt == DEAD_W'(DEAD_CYCLES));

  always_ff @(posedge clk) begin
    if (!supplyOk || !bothOff) begin
      deadCnt <= '0;
    end else if (!deadDone) begin
      deadCnt <= deadCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!supplyOk) begin
      hsGate <= 1'b0;
      lsGate <= 1'b0;
    end else begin
      hsGate <= gateReq.reqHs && (hsGate || (bothOff && deadDone));
      lsGate <= gateReq.reqLs && !gateReq.reqHs && (lsGate || (bothOff && deadDone));
    end
  end

  // R11
  no_overlap_chk: assert property (@(posedge clk) disable iff (!supplyOk)
    !(hsGate && lsGate));

  // R11
  hs_gap_chk: assert property (@(posedge clk) disable iff (!supplyOk)
    $rose(hsGate) |-> $past(!lsGate));

  // R4
  req_drop_chk: assert property (@(posedge clk) disable iff (!supplyOk)
    !gateReq.reqHs |=> !hsGate);

endmodule

// File: rtl/tri_pwm_gate_seq.sv
module tri_pwm_gate_seq
  import tpg_pkg::*;
#(
  parameter int SEL_WINDOW     = 4,
  parameter int BLANK_CYCLES   = 8,
  parameter int TIMEOUT_CYCLES = 1400,
  parameter int DEAD_CYCLES    = 3
) (
  input  logic       clk,
  input  logic       supplyOk,
  input  logic [1:0] pwmCmd,
  input  logic       brakeN,
  input  logic       zeroCross,
  output logic       hsGate,
  output logic       lsGate,
  output logic       modeDiode
);

  gateReq_t gateReq;

  tpg_control #(
    .SEL_WINDOW    (SEL_WINDOW),
    .BLANK_CYCLES  (BLANK_CYCLES),
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
  ) u_control (
    .clk      (clk),
    .supplyOk (supplyOk),
    .pwmCmd   (pwmCmd),
    .brakeN   (brakeN),
    .zeroCross(zeroCross),
    .lsGateFb (lsGate),
    .modeDiode(modeDiode),
    .gateReq  (gateReq)
  );

  tpg_datapath #(
    .DEAD_CYCLES(DEAD_CYCLES)
  ) u_datapath (
    .clk     (clk),
    .supplyOk(supplyOk),
    .gateReq (gateReq),
    .hsGate  (hsGate),
    .lsGate  (lsGate)
  );

  // R4
  brake_off_chk: assert property (@(posedge clk) disable iff (!supplyOk)
    !brakeN |=> (!hsGate && !lsGate));

  // R8
  mid_hs_off_chk: assert property (@(posedge clk) disable iff (!supplyOk)
    pwmCmd[1] |=> !hsGate);

  // R7
  brake_mode_mid_chk: assert property (@(posedge clk) disable iff (!supplyOk)
    (pwmCmd[1] && !modeDiode) |=> !lsGate);

endmodule

// File: tb/tb_tri_pwm_gate_seq.sv
module tb_tri_pwm_gate_seq;

  localparam int SEL  = 4;
  localparam int BLK  = 8;
  localparam int TOUT = 40;
  localparam int DEAD = 3;

  logic       clk = 1'b0;
  logic       supplyOk = 1'b0;
  logic [1:0] pwmCmd = 2'b00;
  logic       brakeN = 1'b1;
  logic       zeroCross = 1'b0;
  logic       hsGate, lsGate, modeDiode;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string tag = "R1";

  // reference model state
  int mMode = 0, mSel = 0, mDe = 0, mTo = 0, mBlank = 0, mDead = 0;
  int mHs = 0, mLs = 0;

  always #10 clk = ~clk;

  tri_pwm_gate_seq #(
    .SEL_WINDOW(SEL), .BLANK_CYCLES(BLK), .TIMEOUT_CYCLES(TOUT), .DEAD_CYCLES(DEAD)
  ) dut (
    .clk(clk), .supplyOk(supplyOk), .pwmCmd(pwmCmd), .brakeN(brakeN),
    .zeroCross(zeroCross), .hsGate(hsGate), .lsGate(lsGate), .modeDiode(modeDiode)
  );

  always @(posedge clk) begin
    int rHs, rLs, nHs, nLs, mid;
    if (!supplyOk) begin
      mMode = 0; mSel = 0; mDe = 0; mTo = 0; mBlank = 0; mDead = 0; mHs = 0; mLs = 0;
    end else begin
      mid = pwmCmd[1];
      rHs = (brakeN && pwmCmd == 2'b01) ? 1 : 0;
      rLs = (brakeN && (pwmCmd == 2'b00 || (mid && mMode == 1 && mDe != 2))) ? 1 : 0;
      nHs = (rHs == 1 && (mHs == 1 || (mHs == 0 && mLs == 0 && mDead == DEAD))) ? 1 : 0;
      nLs = (rLs == 1 && (mLs == 1 || (mHs == 0 && mLs == 0 && mDead == DEAD))) ? 1 : 0;
      if (mid == 0 || mMode == 0) begin
        mDe = 0; mTo = 0;
      end else if (mDe == 0) begin
        mDe = 1; mTo = 0;
      end else if (mDe == 1) begin
        if ((zeroCross && mBlank == BLK) || mTo == TOUT) mDe = 2;
        else mTo++;
      end
      if (mHs == 1 || mLs == 1) mDead = 0; else if (mDead < DEAD) mDead++;
      if (mLs == 0) mBlank = 0; else if (mBlank < BLK) mBlank++;
      if (mSel < SEL) begin
        mSel++;
        if (!brakeN) mMode = 1;
      end
      mHs = nHs; mLs = nLs;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (cycles > 2) begin
      checks++;
      if (hsGate !== mHs[0] || lsGate !== mLs[0] || modeDiode !== mMode[0]) begin
        errors++;
        $display("FAIL %s cycle %0d: hs/ls/mode actual %b%b%b expected %0d%0d%0d",
                 tag, cycles, hsGate, lsGate, modeDiode, mHs, mLs, mMode);
      end
    end
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect1(input string t, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", t, act, exp);
    end
  endtask

  initial begin
    int lsOn;
    // R1 reset state
    tag = "R1"; run(5);
    expect1("R1 hs reset", hsGate, 1'b0);
    expect1("R1 ls reset", lsGate, 1'b0);
    expect1("R1 mode reset", modeDiode, 1'b0);

    // R5 power-up with brake high -> brake mode
    tag = "R5"; supplyOk = 1'b1; pwmCmd = 2'b01; run(8);
    expect1("R5 brake mode kept", modeDiode, 1'b0);
    tag = "R2"; run(6);
    expect1("R2 hs on", hsGate, 1'b1);
    expect1("R2 ls off", lsGate, 1'b0);
    tag = "R3"; pwmCmd = 2'b00; run(10);
    expect1("R3 ls on", lsGate, 1'b1);
    tag = "R11"; pwmCmd = 2'b01; run(10);
    tag = "R4"; brakeN = 1'b0; run(1);
    expect1("R4 hs off under brake", hsGate, 1'b0);
    run(3); brakeN = 1'b1; run(8);
    expect1("R4 resumes after release", hsGate, 1'b1);
    tag = "R7"; pwmCmd = 2'b10; run(10);
    expect1("R7 hs off mid", hsGate, 1'b0);
    expect1("R7 ls off mid", lsGate, 1'b0);
    tag = "R12"; pwmCmd = 2'b00; run(10);
    expect1("R12 ls back on", lsGate, 1'b1);

    // R1 supply drop, then R5 diode selection
    tag = "R1"; supplyOk = 1'b0; run(3);
    expect1("R1 ls off in uvlo", lsGate, 1'b0);
    tag = "R5"; supplyOk = 1'b1; brakeN = 1'b0; pwmCmd = 2'b01; run(2);
    brakeN = 1'b1; run(6);
    expect1("R5 diode mode set", modeDiode, 1'b1);
    tag = "R2"; run(4);

    // R9 zero-cross held from entry: blanking must delay turn-off
    tag = "R9"; zeroCross = 1'b1; pwmCmd = 2'b11; lsOn = 0;
    for (int i = 0; i < 30; i++) begin
      run(1);
      if (lsGate) lsOn++;
    end
    checks++;
    if (lsOn < BLK + 1) begin
      errors++;
      $display("FAIL R9: actual ls-on %0d expected >= %0d", lsOn, BLK + 1);
    end
    expect1("R8 ls off after zero cross", lsGate, 1'b0);
    zeroCross = 1'b0;

    // R12 return to low, then R8/R10 timeout
    tag = "R12"; pwmCmd = 2'b00; run(8);
    expect1("R12 ls on after mid", lsGate, 1'b1);
    tag = "R8"; pwmCmd = 2'b10; run(10);
    expect1("R8 ls held in mid", lsGate, 1'b1);
    expect1("R8 hs off in mid", hsGate, 1'b0);
    tag = "R10"; run(TOUT);
    expect1("R10 ls off after timeout", lsGate, 1'b0);

    // R6 brake activity after selection leaves mode set
    tag = "R6"; pwmCmd = 2'b01; brakeN = 1'b0; run(3); brakeN = 1'b1; run(6);
    expect1("R6 mode sticky", modeDiode, 1'b1);
    supplyOk = 1'b0; run(2);
    expect1("R6 mode cleared by uvlo", modeDiode, 1'b0);
    supplyOk = 1'b1; run(10);
    expect1("R6 brake mode after clean power-up", modeDiode, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule